// File: doc/BRIEF.md
# Indirect Configuration and I/O Port Access Unit

This unit lets a host reach the configuration space and the I/O port space of a downstream bus through a small register window. The host first writes a 32-bit target address into an address register. It then reads or writes one of two data windows. One window produces configuration cycles and the other produces I/O port cycles. For a configuration cycle the address register holds a packed token: bus number in bits 23:16, device/function in bits 15:8, and a dword-aligned register offset in bits 7:0. For an I/O port cycle the 16-bit port number is written into the address register unchanged.

The access size comes from the host's size input: byte, halfword or word. The byte lane comes from the low bits of the window offset. From these the unit builds byte enables, places write data on the proper lanes, and issues a downstream request. For reads it returns the selected lanes right-justified. Window writes are posted: the host is released as soon as the unit accepts the write. Window reads hold the host until the downstream response arrives. Any host access that arrives while a downstream cycle is outstanding is stalled, and this includes a write to the address register. Software that performs a configuration write is expected to do a dummy configuration read of register 0 at the same device first. This avoids a bus-timing hazard. The unit needs no special support for that read.

The sequencer has four states. `S_IDLE` accepts host accesses. `S_ISSUE` presents the downstream request until it is taken. `S_WAIT` waits for the response. `S_RESP` returns read data. The transitions are:
- `S_IDLE`→`S_ISSUE` on any window access.
- `S_ISSUE`→`S_WAIT` on `dn_ready`.
- `S_WAIT`→`S_IDLE` on a response to a write.
- `S_WAIT`→`S_RESP` on a response to a read.
- `S_RESP`→`S_IDLE` unconditionally.

Top module: `cfgio_bridge`

## Requirements
- R1: After reset the unit is idle: `dn_valid`, `host_ack` and `host_busy` are 0, and a read of the address register (offset 0x064) returns 0.
- R2: A host write to offset 0x064 is acknowledged in the cycle it is presented in idle, and a later read of 0x064 returns the written value.
- R3: An access to the configuration window (offsets 0x068–0x06B) issues a downstream request with `dn_io`=0 and `dn_addr` equal to the address register with bits 1:0 forced to zero.
- R4: An access to the I/O window (offsets 0x06C–0x06F) issues a downstream request with `dn_io`=1 and the same `dn_addr` rule as R3.
- R5: Byte enables depend on the size and the window offset. With `host_size`=0 (byte), the enable is one-hot at lane offset[1:0]. With `host_size`=1 (halfword), it is 4'b0011 when offset bit 1 is 0 and 4'b1100 when it is 1; offset bit 0 is ignored. With `host_size`=2 (word), it is 4'b1111 for any offset.
- R6: On a window write, `dn_we`=1 and `dn_wdata` equals the right-justified host data shifted left by 8 times the lane index, where the lane index is the lowest enabled lane.
- R7: On a window read, `host_rdata` returns the enabled lanes of the response shifted down to bit 0, with all bits above the access size zero.
- R8: A window write is acknowledged in the cycle it is accepted. A window read is acknowledged only in the cycle after the downstream response, never in its accepting cycle.
- R9: While a downstream cycle is outstanding (`host_busy`=1), no host access is acknowledged and the address register does not change. A stalled address write takes effect once the unit returns to idle.
- R10: A response with `dn_rsp_abort`=1 makes a read return all ones in the accessed size (0xFF, 0xFFFF or 0xFFFFFFFF). An aborted write is not reported, and the unit returns to idle for the next access.
- R11: Once `dn_valid` is raised, it stays high with `dn_io`, `dn_we`, `dn_addr`, `dn_be` and `dn_wdata` unchanged until the cycle that sees `dn_ready`.
- R12: A host access to any other offset is acknowledged in idle without any downstream request. Such a write changes nothing, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until `host_ack` |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 12 | Host register offset |
| host_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| host_wdata | input | 32 | Right-justified host write data |
| host_ack | output | 1 | Access completed in this cycle |
| host_rdata | output | 32 | Read data, valid with `host_ack` |
| host_busy | output | 1 | A downstream cycle is outstanding |
| dn_valid | output | 1 | Downstream request present |
| dn_ready | input | 1 | Downstream request taken |
| dn_io | output | 1 | 1 = I/O port cycle, 0 = configuration cycle |
| dn_we | output | 1 | 1 = write cycle |
| dn_addr | output | 32 | Dword-aligned cycle address |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-aligned write data |
| dn_rsp_valid | input | 1 | Downstream response, single cycle |
| dn_rsp_abort | input | 1 | Response is a master-abort |
| dn_rdata | input | 32 | Downstream read data, lane-aligned |

## Verification
The assertions rely on three things about the inputs. The host holds `host_req` and its fields steady until `host_ack`. The downstream side raises `dn_ready` only against a valid request. It gives exactly one `dn_rsp_valid` pulse per taken request, and only after `dn_ready`. The bench's responder is the only driver of the downstream inputs, and it follows that sequence with a programmable latency. All host traffic goes through one task that holds the request until acknowledgement. Expected requests are queued by the driver and compared by the responder as each request appears.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_RESP  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_t;

endpackage

// File: rtl/cfgio_lane.sv
module cfgio_lane #(
    parameter int DW = 32
) (
    input  logic [1:0]        size,
    input  logic [1:0]        offs,
    input  logic [DW-1:0]     wdata_in,
    input  logic [DW-1:0]     rword_in,
    output logic [DW/8-1:0]   be,
    output logic [DW-1:0]     wdata_out,
    output logic [DW-1:0]     rdata_out
);
    localparam int NB = DW / 8;
    localparam int LW = (NB > 1) ? $clog2(NB) : 1;

    logic [LW:0]   nbytes;
    logic [LW-1:0] lane;
    logic [DW-1:0] rshift;

    always_comb begin
        unique case (size)
            2'd0:    nbytes = (LW+1)'(1);
            2'd1:    nbytes = (LW+1)'(2);
            default: nbytes = (LW+1)'(NB);
        endcase
        lane = LW'(offs) & ~LW'(nbytes - 1'b1);
        wdata_out = wdata_in << {lane, 3'b000};
        rshift    = rword_in >> {lane, 3'b000};
    end

    for (genvar gi = 0; gi < NB; gi++) begin : g_lane
        assign be[gi] = ((LW+1)'(gi) >= {1'b0, lane}) &&
                        ((LW+1)'(gi) <  ({1'b0, lane} + nbytes));
        assign rdata_out[gi*8 +: 8] = ((LW+1)'(gi) < nbytes) ? rshift[gi*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/cfgio_seq.sv
module cfgio_seq
    import cfgio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_req,
    input  logic       host_we,
    input  logic       sel_addr,
    input  logic       sel_win,
    input  logic       cap_we,
    input  logic       dn_ready,
    input  logic       dn_rsp_valid,
    output seq_state_t state,
    output logic       ack,
    output logic       load_areg,
    output logic       capture,
    output logic       rsp_load,
    output logic       dn_valid,
    output logic       busy
);
    seq_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        ack       = 1'b0;
        load_areg = 1'b0;
        capture   = 1'b0;
        rsp_load  = 1'b0;
        dn_valid  = 1'b0;
        busy      = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (host_req) begin
                    if (sel_win) begin
                        capture  = 1'b1;
                        ack      = host_we;
                        state_nx = S_ISSUE;
                    end else begin
                        ack       = 1'b1;
                        load_areg = sel_addr && host_we;
                    end
                end
            end
            S_ISSUE: begin
                busy     = 1'b1;
                dn_valid = 1'b1;
                if (dn_ready) state_nx = S_WAIT;
            end
            S_WAIT: begin
                busy = 1'b1;
                if (dn_rsp_valid) begin
                    if (cap_we) begin
                        state_nx = S_IDLE;
                    end else begin
                        rsp_load = 1'b1;
                        state_nx = S_RESP;
                    end
                end
            end
            S_RESP: begin
                ack      = 1'b1;
                state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

endmodule

// File: rtl/cfgio_bridge.sv
module cfgio_bridge
    import cfgio_pkg::*;
#(
    parameter int          DW       = 32,
    parameter int          OW       = 12,
    parameter logic [11:0] ADDR_OFS = 12'h064,
    parameter logic [11:0] CFG_OFS  = 12'h068,
    parameter logic [11:0] IO_OFS   = 12'h06C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [OW-1:0]    host_addr,
    input  logic [1:0]       host_size,
    input  logic [DW-1:0]    host_wdata,
    output logic             host_ack,
    output logic [DW-1:0]    host_rdata,
    output logic             host_busy,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic             dn_io,
    output logic             dn_we,
    output logic [31:0]      dn_addr,
    output logic [DW/8-1:0]  dn_be,
    output logic [DW-1:0]    dn_wdata,
    input  logic             dn_rsp_valid,
    input  logic             dn_rsp_abort,
    input  logic [DW-1:0]    dn_rdata
);
    localparam int NB = DW / 8;

    seq_state_t    state;
    logic          ack, load_areg, capture, rsp_load;
    logic          sel_addr, sel_cfg, sel_io, sel_win;
    logic [31:0]   areg_q;
    logic          cap_io, cap_we;
    logic [1:0]    cap_size, cap_offs;
    logic [DW-1:0] cap_wdata, rd_q, rd_just;

    assign sel_addr = host_addr[OW-1:2] == ADDR_OFS[OW-1:2];
    assign sel_cfg  = host_addr[OW-1:2] == CFG_OFS[OW-1:2];
    assign sel_io   = host_addr[OW-1:2] == IO_OFS[OW-1:2];
    assign sel_win  = sel_cfg || sel_io;

    cfgio_seq seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req     (host_req),
        .host_we      (host_we),
        .sel_addr     (sel_addr),
        .sel_win      (sel_win),
        .cap_we       (cap_we),
        .dn_ready     (dn_ready),
        .dn_rsp_valid (dn_rsp_valid),
        .state        (state),
        .ack          (ack),
        .load_areg    (load_areg),
        .capture      (capture),
        .rsp_load     (rsp_load),
        .dn_valid     (dn_valid),
        .busy         (host_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            areg_q    <= '0;
            cap_io    <= 1'b0;
            cap_we    <= 1'b0;
            cap_size  <= 2'd0;
            cap_offs  <= 2'd0;
            cap_wdata <= '0;
            rd_q      <= '0;
        end else begin
            if (load_areg) areg_q <= host_wdata[31:0];
            if (capture) begin
                cap_io    <= sel_io;
                cap_we    <= host_we;
                cap_size  <= host_size;
                cap_offs  <= host_addr[1:0];
                cap_wdata <= host_wdata;
            end
            if (rsp_load) rd_q <= dn_rsp_abort ? '1 : dn_rdata;
        end
    end

    cfgio_lane #(.DW(DW)) lane_i (
        .size      (cap_size),
        .offs      (cap_offs),
        .wdata_in  (cap_wdata),
        .rword_in  (rd_q),
        .be        (dn_be),
        .wdata_out (dn_wdata),
        .rdata_out (rd_just)
    );

    assign dn_io    = cap_io;
    assign dn_we    = cap_we;
    assign dn_addr  = {areg_q[31:2], 2'b00};
    assign host_ack = ack;

    always_comb begin
        if (state == S_RESP)               host_rdata = rd_just;
        else if (sel_addr && state == S_IDLE) host_rdata = DW'(areg_q);
        else                               host_rdata = '0;
    end

    localparam int UNUSED_NB = NB;

endmodule

// File: rtl/cfgio_bridge_chk.sv
module cfgio_bridge_chk #(
    parameter int DW = 32,
    parameter int OW = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_req,
    input logic            host_we,
    input logic [OW-1:0]   host_addr,
    input logic            host_ack,
    input logic            host_busy,
    input logic            dn_valid,
    input logic            dn_ready,
    input logic            dn_io,
    input logic            dn_we,
    input logic [31:0]     dn_addr,
    input logic [DW/8-1:0] dn_be,
    input logic [DW-1:0]   dn_wdata,
    input logic            dn_rsp_valid,
    input logic [31:0]     areg
);
    logic win_rd;
    assign win_rd = host_req && !host_we &&
                    (host_addr[OW-1:2] == 10'h01A || host_addr[OW-1:2] == 10'h01B);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_be) &&
                                  $stable(dn_wdata) && $stable(dn_io) && $stable(dn_we));

    assert_be_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> (dn_be == 4'b0001 || dn_be == 4'b0010 || dn_be == 4'b0100 ||
                      dn_be == 4'b1000 || dn_be == 4'b0011 || dn_be == 4'b1100 ||
                      dn_be == 4'b1111));

    assert_addr_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> dn_addr[1:0] == 2'b00);

    assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> !host_ack);

    assert_areg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |=> $stable(areg));

    assert_rd_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack && win_rd |-> $past(dn_rsp_valid));

endmodule

bind cfgio_bridge cfgio_bridge_chk #(.DW(DW), .OW(OW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .host_we      (host_we),
    .host_addr    (host_addr),
    .host_ack     (host_ack),
    .host_busy    (host_busy),
    .dn_valid     (dn_valid),
    .dn_ready     (dn_ready),
    .dn_io        (dn_io),
    .dn_we        (dn_we),
    .dn_addr      (dn_addr),
    .dn_be        (dn_be),
    .dn_wdata     (dn_wdata),
    .dn_rsp_valid (dn_rsp_valid),
    .areg         (areg_q)
);

// File: tb/cfgio_bridge_tb_top.sv
`timescale 1ns/1ps
module cfgio_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack, host_busy;
    logic [31:0] host_rdata;
    logic        dn_valid, dn_io, dn_we;
    logic        dn_ready = 1'b0;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_be;
    logic        dn_rsp_valid = 1'b0, dn_rsp_abort = 1'b0;
    logic [31:0] dn_rdata = '0;

    always #2.5 clk = ~clk;

    cfgio_bridge dut_i (.*);

    typedef struct packed {
        logic        io;
        logic        we;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
    } dn_item_t;

    dn_item_t exp_q[$];
    int checks = 0, failures = 0;
    int rsp_lat = 0;
    logic [31:0] rsp_data = '0;
    logic        rsp_abort = 1'b0;
    logic [31:0] cur_areg = '0;
    int dn_seen = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'd0:    exp_be = 4'b0001 << off;
            2'd1:    exp_be = off[1] ? 4'b1100 : 4'b0011;
            default: exp_be = 4'b1111;
        endcase
    endfunction

    function automatic int low_lane(input logic [3:0] be);
        for (int i = 3; i >= 0; i--) if (be[i]) low_lane = i;
    endfunction

    // Downstream responder and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (dn_valid) begin
                dn_item_t got, exp;
                got = '{io: dn_io, we: dn_we, addr: dn_addr, be: dn_be, wdata: dn_wdata};
                dn_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12 unexpected downstream request", got.addr, 32'h0);
                end else begin
                    exp = exp_q.pop_front();
                    check(got.io == exp.io, "R3/R4 cycle type", 32'(got.io), 32'(exp.io));
                    check(got.addr == exp.addr, "R3 address", got.addr, exp.addr);
                    check(got.be == exp.be, "R5 byte enables", 32'(got.be), 32'(exp.be));
                    check(got.we == exp.we, "R6 write flag", 32'(got.we), 32'(exp.we));
                    if (exp.we) check(got.wdata == exp.wdata, "R6 write lanes", got.wdata, exp.wdata);
                end
                dn_ready = 1'b1;
                @(negedge clk);
                dn_ready = 1'b0;
                repeat (rsp_lat) @(negedge clk);
                dn_rsp_valid = 1'b1;
                dn_rdata     = rsp_data;
                dn_rsp_abort = rsp_abort;
                @(negedge clk);
                dn_rsp_valid = 1'b0;
                dn_rsp_abort = 1'b0;
            end
        end
    end

    task automatic host_access(input logic we, input logic [11:0] ofs, input logic [1:0] sz,
                               input logic [31:0] wd, output logic [31:0] rd, output int waits);
        if (ofs[11:2] == 10'h01A || ofs[11:2] == 10'h01B) begin
            dn_item_t e;
            logic [3:0] b;
            b = exp_be(sz, ofs[1:0]);
            e.io = (ofs[11:2] == 10'h01B);
            e.we = we;
            e.addr = {cur_areg[31:2], 2'b00};
            e.be = b;
            e.wdata = wd << (8 * low_lane(b));
            exp_q.push_back(e);
        end
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = ofs; host_size = sz; host_wdata = wd;
        waits = 0;
        #1;
        while (!host_ack && waits < 1000) begin
            @(negedge clk); #1; waits++;
        end
        rd = host_rdata;
        @(posedge clk); #1;
        host_req = 1'b0;
        if (ofs[11:2] == 10'h019 && we) cur_areg = wd;
    endtask

    function automatic logic [31:0] exp_rd(input logic [31:0] word, input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'd0:    exp_rd = {24'h0, word[8*off +: 8]};
            2'd1:    exp_rd = off[1] ? {16'h0, word[31:16]} : {16'h0, word[15:0]};
            default: exp_rd = word;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int w;
        int seen0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dn_valid == 1'b0, "R1 dn_valid", 32'(dn_valid), 0);
        check(host_ack == 1'b0, "R1 host_ack", 32'(host_ack), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_busy == 1'b0, "R1 host_busy", 32'(host_busy), 0);
        host_access(1'b0, 12'h064, 2'd2, 0, rd, w);
        check(rd == 32'h0, "R1 address register reset", rd, 0);

        // R2 address register write and readback
        host_access(1'b1, 12'h064, 2'd2, 32'h0012_3A0C, rd, w);
        check(w == 0, "R2 immediate ack", w, 0);
        host_access(1'b0, 12'h064, 2'd2, 0, rd, w);
        check(rd == 32'h0012_3A0C, "R2 readback", rd, 32'h0012_3A0C);

        // R3 R6 R8 configuration word write, posted
        host_access(1'b1, 12'h068, 2'd2, 32'hCAFE_F00D, rd, w);
        check(w == 0, "R8 posted write ack", w, 0);

        // R5 R7 byte reads on all lanes
        rsp_data = 32'h4433_2211;
        for (int k = 0; k < 4; k++) begin
            host_access(1'b0, 12'h068 + 12'(k), 2'd0, 0, rd, w);
            check(rd == exp_rd(rsp_data, 2'd0, 2'(k)), "R7 byte read", rd, exp_rd(rsp_data, 2'd0, 2'(k)));
            check(w >= 2, "R8 read waits for response", w, 2);
        end
        // halfword reads, bit 0 ignored
        host_access(1'b0, 12'h068, 2'd1, 0, rd, w);
        check(rd == 32'h0000_2211, "R7 low halfword", rd, 32'h0000_2211);
        host_access(1'b0, 12'h06B, 2'd1, 0, rd, w);
        check(rd == 32'h0000_4433, "R5 R7 high halfword odd offset", rd, 32'h0000_4433);

        // R4 I/O port accesses
        host_access(1'b1, 12'h064, 2'd2, 32'h0000_03F9, rd, w);
        host_access(1'b1, 12'h06D, 2'd0, 32'h0000_00A5, rd, w);
        host_access(1'b1, 12'h06E, 2'd1, 32'h0000_BEEF, rd, w);
        rsp_data = 32'h8765_4321;
        host_access(1'b0, 12'h06E, 2'd2, 0, rd, w);
        check(rd == 32'h8765_4321, "R5 R7 word ignores offset", rd, 32'h8765_4321);

        // R10 master abort
        rsp_abort = 1'b1;
        host_access(1'b0, 12'h06C, 2'd0, 0, rd, w);
        check(rd == 32'h0000_00FF, "R10 abort byte", rd, 32'h0000_00FF);
        host_access(1'b0, 12'h06A, 2'd1, 0, rd, w);
        check(rd == 32'h0000_FFFF, "R10 abort halfword", rd, 32'h0000_FFFF);
        host_access(1'b0, 12'h068, 2'd2, 0, rd, w);
        check(rd == 32'hFFFF_FFFF, "R10 abort word", rd, 32'hFFFF_FFFF);
        host_access(1'b1, 12'h06C, 2'd0, 32'h11, rd, w);
        rsp_abort = 1'b0;
        rsp_data = 32'h0000_5A00;
        host_access(1'b0, 12'h06D, 2'd0, 0, rd, w);
        check(rd == 32'h0000_005A, "R10 normal read after aborted write", rd, 32'h5A);

        // R9 stall of address write behind a posted write
        rsp_lat = 6;
        host_access(1'b1, 12'h068, 2'd2, 32'h0BAD_BEEF, rd, w);
        host_access(1'b1, 12'h064, 2'd2, 32'h0001_0804, rd, w);
        check(w >= 6, "R9 address write stalled", w, 6);
        rsp_lat = 0;
        host_access(1'b0, 12'h064, 2'd2, 0, rd, w);
        check(rd == 32'h0001_0804, "R9 stalled write applied", rd, 32'h0001_0804);
        rsp_data = 32'h1234_5678;
        host_access(1'b0, 12'h068, 2'd2, 0, rd, w);
        check(rd == 32'h1234_5678, "R3 read at new address", rd, 32'h1234_5678);

        // R12 unknown offsets
        repeat (4) @(negedge clk);
        seen0 = dn_seen;
        host_access(1'b1, 12'h070, 2'd2, 32'hFFFF_FFFF, rd, w);
        check(w == 0, "R12 unknown write acked", w, 0);
        host_access(1'b0, 12'h070, 2'd2, 0, rd, w);
        check(rd == 32'h0, "R12 unknown read zero", rd, 0);
        host_access(1'b0, 12'h064, 2'd2, 0, rd, w);
        check(rd == 32'h0001_0804, "R12 address register untouched", rd, 32'h0001_0804);
        repeat (4) @(negedge clk);
        check(dn_seen == seen0, "R12 no downstream request", 32'(dn_seen), 32'(seen0));
        check(exp_q.size() == 0, "R11 all expected requests seen", 32'(exp_q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule